// File: doc/BRIEF.md
# Prescaled Multi-Channel Down-Counter Timer

This block holds a shared 16-bit prescaler and a set of 32-bit down-counters, by default two. The prescaler counts down on the system clock and, each time it passes zero, issues a tick that moves every enabled counter one step down. A counter that is at zero when a tick arrives underflows. On underflow it either takes its reload value again or parks at all ones, and it can raise a one-cycle interrupt pulse on its own output line.

Software drives the block through a simple APB-style register port. A write is taken in the access phase (select, enable and write all high) and acts on the following clock edge. Read data is combinational and valid while select is high with write low. Each control register has a load command bit, which copies the reload value into the counter at once and is not stored. A read-only word reports the interrupt level of the first timer and the number of timers.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the prescaler reload reads 0xFFFF, timer 0's counter and reload read 0xFFFFFFFF, every control register reads 0, the other timers' counters and reloads read 0, and no interrupt output is high.
- R2: The prescaler value (offset 0x00) counts down by one per clock from its reload (offset 0x04) to 0, and then starts again from the reload, which gives one tick every reload+1 clocks. A write to the reload loads the new value into the count on the write edge.
- R3: In a control register (offset 0x18+0x10·n), bit 0 enable, bit 1 auto-reload and bit 3 interrupt enable are stored and read back. Bit 2 (load) always reads 0.
- R4: A control write with bit 2 set copies the stored reload value into the counter on the write edge. This takes priority over a tick in the same cycle and produces no interrupt.
- R5: An enabled counter holding value v underflows on the (v+1)th tick. A disabled counter keeps its value.
- R6: On underflow the counter takes the reload value when auto-reload is set, and 0xFFFFFFFF otherwise.
- R7: An underflow drives interrupt bit n (timer n, level IRQ_BASE+n) high for one cycle when interrupt enable is set. With interrupt enable clear, no pulse appears.
- R8: The configuration word (offset 0x08) reads 0x100 | (IRQ_BASE<<3) | NTIM, which is 0x142 with the default parameters.
- R9: Counter (offset 0x10+0x10·n) and reload (offset 0x14+0x10·n) writes take effect on the write edge. A counter write on the same edge as an underflow wins and suppresses that interrupt.
- R10: Register offsets decode as listed above. Accesses with paddr[1:0] not zero are ignored, and unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW (8) | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel=1 and pwrite=0 |
| irq | output | NTIM (2) | One-cycle underflow pulse per timer; bit n stands for level IRQ_BASE+n |

## Verification
Two kinds of event can land on the same clock edge. The first is a software write to a counter or control register. The second is a prescaler tick that would decrement or underflow that counter. The bench sets the prescaler reload to 0, so a tick arrives on every edge. It then issues a control write with the load bit while the counter is enabled, and a counter write timed to land exactly on the underflow edge. The result is judged by reading the counter straight after that edge: it must hold the written or loaded value and not the reloaded or decremented one, and no interrupt pulse may appear.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  // Bit positions inside a timer control word
  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_ARLD = 1;
  localparam int unsigned CB_LOAD = 2;
  localparam int unsigned CB_IE   = 3;

  // Word index (paddr[3:2]) inside the common block and inside a timer block
  localparam logic [1:0] CMN_PVAL = 2'd0;
  localparam logic [1:0] CMN_PRLD = 2'd1;
  localparam logic [1:0] CMN_CFG  = 2'd2;
  localparam logic [1:0] TSL_CNT  = 2'd0;
  localparam logic [1:0] TSL_RLD  = 2'd1;
  localparam logic [1:0] TSL_CTL  = 2'd2;

  typedef struct packed {
    logic ie;
    logic arld;
    logic en;
  } tctl_t;

endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rld_we,
  input  logic [W-1:0] rld_wd,
  output logic [W-1:0] val,
  output logic [W-1:0] rld,
  output logic         tick
);

  assign tick = (val == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '1;
      rld <= '1;
    end else if (rld_we) begin
      // a new reload restarts the count from that value
      rld <= rld_wd;
      val <= rld_wd;
    end else if (tick) begin
      val <= rld;
    end else begin
      val <= val - 1'b1;
    end
  end

endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cnt_we,
  input  logic         rld_we,
  input  logic         ctl_we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rld,
  output tctl_t        ctl,
  output logic         irq
);

  logic uflow;
  logic load_cmd;

  assign uflow    = ctl.en && tick && (cnt == '0);
  assign load_cmd = ctl_we && wd[CB_LOAD];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= RST_VAL;
      rld <= RST_VAL;
      ctl <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (rld_we) rld <= wd;
      if (ctl_we) begin
        ctl.en   <= wd[CB_EN];
        ctl.arld <= wd[CB_ARLD];
        ctl.ie   <= wd[CB_IE];
      end
      // priority: software write, load command, underflow, decrement
      if (cnt_we) begin
        cnt <= wd;
      end else if (load_cmd) begin
        cnt <= rld;
      end else if (uflow) begin
        cnt <= ctl.arld ? rld : '1;
        irq <= ctl.ie;
      end else if (ctl.en && tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int unsigned NTIM     = 2,
  parameter int unsigned IRQ_BASE = 8,
  parameter int unsigned PRE_W    = 16,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned AW       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [AW-1:0]   paddr,
  input  logic [31:0]     pwdata,
  output logic [31:0]     prdata,
  output logic [NTIM-1:0] irq
);

  localparam int unsigned BW = AW - 4;
  localparam logic [31:0] CFG_WORD =
    32'h100 | 32'(IRQ_BASE << 3) | 32'(NTIM);

  logic          wr;
  logic          aligned;
  logic [BW-1:0] blk;
  logic [1:0]    sub;

  logic [PRE_W-1:0] pre_val;
  logic [PRE_W-1:0] pre_rld;
  logic             tick;

  logic [NTIM-1:0][CNT_W-1:0] cnt_v;
  logic [NTIM-1:0][CNT_W-1:0] rld_v;
  tctl_t [NTIM-1:0]           ctl_v;
  logic [NTIM-1:0]            en_v;
  logic [NTIM-1:0]            arld_v;
  logic [NTIM-1:0]            ie_v;

  assign aligned = (paddr[1:0] == 2'b00);
  assign blk     = paddr[AW-1:4];
  assign sub     = paddr[3:2];
  assign wr      = psel && penable && pwrite && aligned;

  tmr_prescaler #(.W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .rld_we (wr && (blk == '0) && (sub == CMN_PRLD)),
    .rld_wd (pwdata[PRE_W-1:0]),
    .val    (pre_val),
    .rld    (pre_rld),
    .tick   (tick)
  );

  for (genvar n = 0; n < NTIM; n++) begin : g_ch
    localparam logic [BW-1:0] SLOT = BW'(n + 1);
    logic hit;
    assign hit = wr && (blk == SLOT);

    tmr_channel #(
      .W       (CNT_W),
      .RST_VAL ((n == 0) ? {CNT_W{1'b1}} : {CNT_W{1'b0}})
    ) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .cnt_we (hit && (sub == TSL_CNT)),
      .rld_we (hit && (sub == TSL_RLD)),
      .ctl_we (hit && (sub == TSL_CTL)),
      .wd     (pwdata[CNT_W-1:0]),
      .cnt    (cnt_v[n]),
      .rld    (rld_v[n]),
      .ctl    (ctl_v[n]),
      .irq    (irq[n])
    );

    assign en_v[n]   = ctl_v[n].en;
    assign arld_v[n] = ctl_v[n].arld;
    assign ie_v[n]   = ctl_v[n].ie;
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite && aligned) begin
      if (blk == '0) begin
        case (sub)
          CMN_PVAL: prdata = 32'(pre_val);
          CMN_PRLD: prdata = 32'(pre_rld);
          CMN_CFG:  prdata = CFG_WORD;
          default:  prdata = '0;
        endcase
      end
      for (int n = 0; n < NTIM; n++) begin
        if (blk == BW'(n + 1)) begin
          case (sub)
            TSL_CNT: prdata = 32'(cnt_v[n]);
            TSL_RLD: prdata = 32'(rld_v[n]);
            TSL_CTL: prdata = 32'({ie_v[n], 1'b0, arld_v[n], en_v[n]});
            default: prdata = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/tmr_unit_chk.sv
`timescale 1ns/1ps
module tmr_unit_chk #(
  parameter int unsigned NTIM     = 2,
  parameter int unsigned IRQ_BASE = 8,
  parameter int unsigned PRE_W    = 16,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned AW       = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       psel,
  input logic                       penable,
  input logic                       pwrite,
  input logic [AW-1:0]              paddr,
  input logic [PRE_W-1:0]           pw_lo,
  input logic                       pw_load,
  input logic [31:0]                prdata,
  input logic [NTIM-1:0]            irq,
  input logic [PRE_W-1:0]           pre_val,
  input logic [NTIM-1:0]            en_v,
  input logic [NTIM-1:0]            arld_v,
  input logic [NTIM-1:0]            ie_v,
  input logic [NTIM-1:0][CNT_W-1:0] cnt_v,
  input logic [NTIM-1:0][CNT_W-1:0] rld_v
);

  localparam logic [31:0] CFG_EXP = 32'h100 | 32'(IRQ_BASE << 3) | 32'(NTIM);

  logic wr_any;
  assign wr_any = psel && penable && pwrite;

  // R2: a reload write restarts the prescaler from the written value
  p_pre_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && paddr == AW'(4)) |=> (pre_val == $past(pw_lo)))
    else $error("p_pre_restart_r2");

  // R8: configuration word
  p_cfg_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && paddr == AW'(8)) |-> (prdata == CFG_EXP))
    else $error("p_cfg_word_r8");

  for (genvar n = 0; n < NTIM; n++) begin : g_a
    localparam logic [AW-1:0] CTL_ADR = AW'(16 * (n + 1) + 8);

    // R7: a pulse needs interrupt enable set before the edge
    p_irq_needs_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq[n] |-> $past(ie_v[n]))
      else $error("p_irq_needs_ie_r7");

    // R5: a disabled counter with no bus write stays put
    p_hold_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_v[n] && !wr_any) |=> $stable(cnt_v[n]))
      else $error("p_hold_when_off_r5");

    // R6: value after an underflow follows the auto-reload bit
    p_uflow_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq[n] |-> (cnt_v[n] == ($past(arld_v[n]) ? $past(rld_v[n]) : {CNT_W{1'b1}})))
      else $error("p_uflow_value_r6");

    // R4: the load command copies the reload and raises no pulse
    p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && paddr == CTL_ADR && pw_load) |=> (cnt_v[n] == $past(rld_v[n]) && !irq[n]))
      else $error("p_load_wins_r4");
  end

endmodule

bind tmr_unit tmr_unit_chk #(
  .NTIM(NTIM), .IRQ_BASE(IRQ_BASE), .PRE_W(PRE_W), .CNT_W(CNT_W), .AW(AW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pw_lo   (pwdata[PRE_W-1:0]),
  .pw_load (pwdata[2]),
  .prdata  (prdata),
  .irq     (irq),
  .pre_val (pre_val),
  .en_v    (en_v),
  .arld_v  (arld_v),
  .ie_v    (ie_v),
  .cnt_v   (cnt_v),
  .rld_v   (rld_v)
);

// File: tb/sim_tmr_unit.sv
`timescale 1ns/1ps
module sim_tmr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [1:0]  irq;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  tmr_unit u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  // {write, addr, data, expected read}
  localparam logic [72:0] VEC [12] = '{
    {1'b1, 8'h14, 32'h0000_1234, 32'h0},
    {1'b0, 8'h14, 32'h0,         32'h0000_1234},
    {1'b1, 8'h18, 32'h0000_000E, 32'h0},
    {1'b0, 8'h18, 32'h0,         32'h0000_000A},
    {1'b0, 8'h10, 32'h0,         32'h0000_1234},
    {1'b1, 8'h24, 32'hCAFE_F00D, 32'h0},
    {1'b1, 8'h20, 32'h0000_0055, 32'h0},
    {1'b0, 8'h20, 32'h0,         32'h0000_0055},
    {1'b0, 8'h24, 32'h0,         32'hCAFE_F00D},
    {1'b0, 8'h08, 32'h0,         32'h0000_0142},
    {1'b1, 8'h2A, 32'h0000_0009, 32'h0},
    {1'b0, 8'h28, 32'h0,         32'h0000_0000}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_peek(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    #1;
    d = prdata;
    psel = 1'b0;
  endtask

  task automatic wait_irq(input int bitn, output int k);
    k = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (irq[bitn]) begin
        k = i;
        break;
      end
    end
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] d2;
    int k;
    int cnt_irq;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_peek(8'h04, d); check(d == 32'hFFFF, "R1 prescaler reload", d, 32'hFFFF);
    bus_peek(8'h10, d); check(d == '1, "R1 timer0 counter", d, '1);
    bus_peek(8'h14, d); check(d == '1, "R1 timer0 reload", d, '1);
    bus_peek(8'h18, d); check(d == 0, "R1 timer0 control", d, 0);
    bus_peek(8'h28, d); check(d == 0, "R1 timer1 control", d, 0);
    bus_peek(8'h20, d); check(d == 0, "R1 timer1 counter", d, 0);
    bus_peek(8'h24, d); check(d == 0, "R1 timer1 reload", d, 0);
    check(irq == 2'b00, "R1 irq idle", 32'(irq), 0);

    // vector table: R3 R4 R8 R9 R10
    for (int i = 0; i < 12; i++) begin
      logic [72:0] v;
      v = VEC[i];
      if (v[72]) begin
        bus_wr(v[71:64], v[63:32]);
      end else begin
        bus_peek(v[71:64], d);
        if (d != v[31:0])
          $display("FAIL vector %0d (R3 R4 R8 R9 R10) addr=%h actual=%h expected=%h",
                   i, v[71:64], d, v[31:0]);
        nchk++;
        if (d != v[31:0]) nerr++;
      end
    end

    // R2 prescaler countdown and restart
    bus_wr(8'h04, 32'd3);
    for (int i = 0; i < 5; i++) begin
      logic [31:0] e;
      e = (i < 4) ? 32'(3 - i) : 32'd3;
      if (i > 0) @(negedge clk);
      bus_peek(8'h00, d);
      check(d == e, "R2 prescaler value", d, e);
    end

    // prescaler reload 0: one tick per clock
    bus_wr(8'h04, 32'd0);

    // R5 R6 R7 auto-reload with interrupt
    bus_wr(8'h14, 32'd5);
    bus_wr(8'h18, 32'h0000_000F);
    bus_peek(8'h10, d); check(d == 5, "R4 load on control write", d, 5);
    wait_irq(0, k);
    check(k == 6, "R5 underflow after v+1 ticks", 32'(k), 6);
    bus_peek(8'h10, d); check(d == 5, "R6 auto-reload value", d, 5);
    @(negedge clk);
    check(irq[0] == 1'b0, "R7 pulse lasts one cycle", 32'(irq[0]), 0);

    // R6 no auto-reload: parks at all ones
    bus_wr(8'h14, 32'd2);
    bus_wr(8'h18, 32'h0000_000D);
    wait_irq(0, k);
    check(k == 3, "R5 underflow after 3 ticks", 32'(k), 3);
    bus_peek(8'h10, d); check(d == '1, "R6 all ones without auto-reload", d, '1);

    // R7 interrupt enable clear: no pulse
    bus_wr(8'h18, 32'h0000_0007);
    cnt_irq = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq[0]) cnt_irq++;
    end
    check(cnt_irq == 0, "R7 no pulse with ie clear", 32'(cnt_irq), 0);

    // R5 disabled counter holds
    bus_wr(8'h18, 32'h0);
    bus_peek(8'h10, d);
    repeat (10) @(negedge clk);
    bus_peek(8'h10, d2);
    check(d2 == d, "R5 disabled counter holds", d2, d);

    // R7 timer 1 on its own line
    bus_wr(8'h24, 32'd1);
    bus_wr(8'h28, 32'h0000_000D);
    wait_irq(1, k);
    check(k == 2, "R7 timer1 underflow", 32'(k), 2);
    check(irq[0] == 1'b0, "R7 timer0 line quiet", 32'(irq[0]), 0);
    bus_wr(8'h28, 32'h0);

    // R9 counter write lands on the underflow edge
    bus_wr(8'h14, 32'd3);
    bus_wr(8'h18, 32'h0000_000F);
    @(negedge clk);
    bus_wr(8'h10, 32'd100);
    bus_peek(8'h10, d); check(d == 100, "R9 write wins over underflow", d, 100);
    check(irq[0] == 1'b0, "R9 underflow pulse suppressed", 32'(irq[0]), 0);

    summary();
  end

endmodule